// File: doc/BRIEF.md
# Opmask Move Unit

This unit keeps the eight 64-bit opmask registers of a small vector core and runs the mask-move instruction group against them. The front end hands over an instruction that has already been split into fields. These fields are the opcode byte, a two-bit mandatory-prefix class, the W and L bits, the three ModRM fields and a flag that says whether the core runs in 64-bit mode. With the instruction come two operands that other blocks have already fetched: the load data for the memory-source form, and the GPR value read through the rm field.

The unit decodes the operand size and checks that the field combination is legal. It then does one of five things. It can copy one mask to another, load a mask from memory data, store a mask, move a GPR into a mask, or move a mask into a GPR. All results leave through registered ports one clock after the instruction is presented: a GPR write port, a memory request with byte enables and store data, and an undefined-opcode fault. Address generation and the GPR file are outside the unit.

Top module: `mskmv_unit`

## Requirements
- R1: After reset all eight mask registers read as zero, and `ud_fault`, `gpr_we` and `mem_req` are low.
- R2: Opcode 0x90 with mod=3 writes mask[reg] with mask[rm], cut to the operand size and zero-extended to 64 bits. It raises no memory request.
- R3: Opcode 0x90 with mod≠3 raises `mem_req` with `mem_we`=0 and byte enables for the operand size. It writes mask[reg] with `ld_data`, cut to the operand size and zero-extended.
- R4: Opcode 0x91 with mod≠3 raises `mem_req` with `mem_we`=1. The low 1, 2, 4 or 8 bits of `mem_be` are set (values 0x01, 0x03, 0x0F, 0xFF). `mem_wdata` carries the low operand-size bytes of mask[reg], and the bytes above them are zero. No mask changes.
- R5: Opcode 0x92 with mod=3 writes mask[reg] with `gpr_rdata`, cut to the operand size and zero-extended.
- R6: Opcode 0x93 with mod=3 raises `gpr_we` with `gpr_waddr`=reg. `gpr_wdata` is mask[rm] cut to the operand size and zero-extended. In 32-bit mode bits 63:32 are always zero.
- R7: For 0x90/0x91 the size comes from the prefix class (0=none, 1=66, 2=F2, 3=F3) and W: none/W0 gives 16 bits, 66/W0 gives 8, none/W1 gives 64, 66/W1 gives 32.
- R8: For 0x92/0x93 the size comes from the prefix class and W: none/W0 gives 16 bits, 66/W0 gives 8, F2/W0 gives 32, F2/W1 gives 64.
- R9: Opcode 0x91 with mod=3 is undefined. Opcodes 0x92 and 0x93 with mod≠3 are undefined.
- R10: Prefix F2 with W=1 on 0x92 or 0x93 is undefined when `in_mode64`=0.
- R11: These are undefined: L=1, a prefix/W pair not listed in R7 or R8, and an opcode outside 0x90–0x93.
- R12: An undefined instruction pulses `ud_fault` in the next cycle. It writes no mask and raises neither `gpr_we` nor `mem_req`.
- R13: Outputs appear in the cycle after `in_valid` and last one cycle. A mask written by one instruction is seen by the next one. Registers other than the destination keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_opcode | input | 8 | Opcode byte |
| in_pfx | input | 2 | Prefix class: 0 none, 1 66, 2 F2, 3 F3 |
| in_w | input | 1 | W bit |
| in_l | input | 1 | L bit |
| in_mod | input | 2 | ModRM.mod |
| in_reg | input | 3 | ModRM.reg |
| in_rm | input | 3 | ModRM.rm |
| in_mode64 | input | 1 | Core in 64-bit mode |
| ld_data | input | 64 | Memory data for the load form |
| gpr_rdata | input | 64 | GPR value for the GPR-source form |
| gpr_we | output | 1 | GPR write strobe |
| gpr_waddr | output | 3 | GPR index to write |
| gpr_wdata | output | 64 | GPR write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a store |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Store data |
| ud_fault | output | 1 | Undefined-opcode pulse |

## Verification
The bench targets the two size tables. Their rows differ: W=1 with no prefix means 64 bits for 0x90 but is undefined for 0x92, so a design that shares one table would write a mask where it should fault. It also drives each mod rule in the wrong direction and the 64-bit GPR form in 32-bit mode. A guard that is missing there would show up as a changed mask or a stray GPR write. Store byte enables and upper data bytes are checked at every size, and a mask read right after its write catches a write that lands a cycle late.

// File: rtl/mskmv_pkg.sv
package mskmv_pkg;
  localparam int MASK_W = 64;
  localparam int GPR_W  = 64;
  localparam int BE_W   = MASK_W / 8;

  typedef enum logic [1:0] {PFX_NONE = 2'd0, PFX_66 = 2'd1, PFX_F2 = 2'd2, PFX_F3 = 2'd3} pfx_e;
  typedef enum logic [1:0] {SZ8, SZ16, SZ32, SZ64} osz_e;
  typedef enum logic [2:0] {ACT_NONE, ACT_K2K, ACT_LOAD, ACT_STORE, ACT_G2K, ACT_K2G} act_e;

  typedef struct packed {
    logic ud;
    act_e act;
    osz_e sz;
  } dec_t;

  function automatic logic [MASK_W-1:0] size_mask(osz_e s);
    logic [MASK_W-1:0] m;
    case (s)
      SZ8:     m = MASK_W'(64'h0000_0000_0000_00FF);
      SZ16:    m = MASK_W'(64'h0000_0000_0000_FFFF);
      SZ32:    m = MASK_W'(64'h0000_0000_FFFF_FFFF);
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic logic [BE_W-1:0] size_be(osz_e s);
    logic [BE_W-1:0] b;
    case (s)
      SZ8:     b = BE_W'(8'h01);
      SZ16:    b = BE_W'(8'h03);
      SZ32:    b = BE_W'(8'h0F);
      default: b = '1;
    endcase
    return b;
  endfunction

  function automatic logic [MASK_W-1:0] be_to_bits(logic [BE_W-1:0] be);
    logic [MASK_W-1:0] m;
    for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/mskmv_decode.sv
module mskmv_decode
  import mskmv_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] opcode,
  input  logic [1:0] pfx,
  input  logic       w,
  input  logic       l,
  input  logic [1:0] mod,
  input  logic       mode64,
  output dec_t       dec
);
  pfx_e pc;
  logic fam, kk_grp, gk_grp, pfx_ok, mod_ok, m64_ok, legal;
  osz_e sz;

  always_comb begin
    pc     = pfx_e'(pfx);
    fam    = (opcode[7:2] == 6'b100100);
    kk_grp = fam && !opcode[1];
    gk_grp = fam &&  opcode[1];
    sz     = SZ16;
    pfx_ok = 1'b0;
    if (kk_grp) begin
      case ({pc, w})
        {PFX_NONE, 1'b0}: begin sz = SZ16; pfx_ok = 1'b1; end
        {PFX_66,   1'b0}: begin sz = SZ8;  pfx_ok = 1'b1; end
        {PFX_NONE, 1'b1}: begin sz = SZ64; pfx_ok = 1'b1; end
        {PFX_66,   1'b1}: begin sz = SZ32; pfx_ok = 1'b1; end
        default:          begin sz = SZ16; pfx_ok = 1'b0; end
      endcase
    end else if (gk_grp) begin
      case ({pc, w})
        {PFX_NONE, 1'b0}: begin sz = SZ16; pfx_ok = 1'b1; end
        {PFX_66,   1'b0}: begin sz = SZ8;  pfx_ok = 1'b1; end
        {PFX_F2,   1'b0}: begin sz = SZ32; pfx_ok = 1'b1; end
        {PFX_F2,   1'b1}: begin sz = SZ64; pfx_ok = 1'b1; end
        default:          begin sz = SZ16; pfx_ok = 1'b0; end
      endcase
    end
    case (opcode[1:0])
      2'b00:   mod_ok = 1'b1;
      2'b01:   mod_ok = (mod != 2'b11);
      default: mod_ok = (mod == 2'b11);
    endcase
    m64_ok = mode64 || !(gk_grp && pc == PFX_F2 && w);
    legal  = fam && !l && pfx_ok && mod_ok && m64_ok;

    dec.sz = sz;
    dec.ud = valid && !legal;
    if (!(valid && legal)) dec.act = ACT_NONE;
    else begin
      case (opcode[1:0])
        2'b00:   dec.act = (mod == 2'b11) ? ACT_K2K : ACT_LOAD;
        2'b01:   dec.act = ACT_STORE;
        2'b10:   dec.act = ACT_G2K;
        default: dec.act = ACT_K2G;
      endcase
    end
  end
endmodule

// File: rtl/mskmv_regfile.sv
module mskmv_regfile #(
  parameter int NREG = 8,
  parameter int W    = 64,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic         en;
    logic [W-1:0] d;

    always_comb begin
      en = we && (waddr == AW'(i));
      d  = en ? wdata : q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= d;
    end

    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && waddr == AW'(i)) |=> $stable(q[i]));
  end

  assign rdata_a = q[raddr_a];
  assign rdata_b = q[raddr_b];
endmodule

// File: rtl/mskmv_exec.sv
module mskmv_exec
  import mskmv_pkg::*;
#(
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  dec_t              dec,
  input  logic              mode64,
  input  logic [AW-1:0]     reg_idx,
  input  logic [MASK_W-1:0] ld_data,
  input  logic [GPR_W-1:0]  gpr_rdata,
  input  logic [MASK_W-1:0] k_rm,
  input  logic [MASK_W-1:0] k_reg,
  output logic              kwe,
  output logic [AW-1:0]     kwaddr,
  output logic [MASK_W-1:0] kwdata,
  output logic              gpr_we,
  output logic [AW-1:0]     gpr_waddr,
  output logic [GPR_W-1:0]  gpr_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BE_W-1:0]   mem_be,
  output logic [MASK_W-1:0] mem_wdata,
  output logic              ud_fault
);
  logic [MASK_W-1:0] src, val;
  logic              gwe_d, req_d, mwe_d, ud_d;
  logic [GPR_W-1:0]  gdat_d;
  logic [BE_W-1:0]   be_d;
  logic [MASK_W-1:0] wdat_d;

  always_comb begin
    case (dec.act)
      ACT_K2K, ACT_K2G: src = k_rm;
      ACT_LOAD:         src = ld_data;
      ACT_STORE:        src = k_reg;
      ACT_G2K:          src = MASK_W'(gpr_rdata);
      default:          src = '0;
    endcase
    val    = src & size_mask(dec.sz);
    kwe    = (dec.act == ACT_K2K) || (dec.act == ACT_LOAD) || (dec.act == ACT_G2K);
    kwaddr = reg_idx;
    kwdata = val;
    gwe_d  = (dec.act == ACT_K2G);
    gdat_d = mode64 ? GPR_W'(val) : {{(GPR_W-32){1'b0}}, val[31:0]};
    req_d  = (dec.act == ACT_LOAD) || (dec.act == ACT_STORE);
    mwe_d  = (dec.act == ACT_STORE);
    be_d   = req_d ? size_be(dec.sz) : '0;
    wdat_d = mwe_d ? val : '0;
    ud_d   = dec.ud;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpr_we    <= 1'b0;
      gpr_waddr <= '0;
      gpr_wdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_be    <= '0;
      mem_wdata <= '0;
      ud_fault  <= 1'b0;
    end else begin
      gpr_we    <= gwe_d;
      gpr_waddr <= reg_idx;
      gpr_wdata <= gdat_d;
      mem_req   <= req_d;
      mem_we    <= mwe_d;
      mem_be    <= be_d;
      mem_wdata <= wdat_d;
      ud_fault  <= ud_d;
    end
  end

  assert_fault_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> (!gpr_we && !mem_req));
  assert_be_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 8'h01 || mem_be == 8'h03 || mem_be == 8'h0F || mem_be == 8'hFF));
  assert_store_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_wdata & ~be_to_bits(mem_be)) == '0));
  assert_gpr32_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr_we && !$past(mode64)) |-> (gpr_wdata[GPR_W-1:32] == '0));
  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !(ud_fault || gpr_we || mem_req));
endmodule

// File: rtl/mskmv_unit.sv
module mskmv_unit
  import mskmv_pkg::*;
#(
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_opcode,
  input  logic [1:0]        in_pfx,
  input  logic              in_w,
  input  logic              in_l,
  input  logic [1:0]        in_mod,
  input  logic [AW-1:0]     in_reg,
  input  logic [AW-1:0]     in_rm,
  input  logic              in_mode64,
  input  logic [MASK_W-1:0] ld_data,
  input  logic [GPR_W-1:0]  gpr_rdata,
  output logic              gpr_we,
  output logic [AW-1:0]     gpr_waddr,
  output logic [GPR_W-1:0]  gpr_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BE_W-1:0]   mem_be,
  output logic [MASK_W-1:0] mem_wdata,
  output logic              ud_fault
);
  logic [1:0] rst_sync_q, rst_sync_d;
  logic       rst_q;

  always_comb rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= rst_sync_d;
  end
  assign rst_q = rst_sync_q[1];

  dec_t              dec;
  logic              kwe;
  logic [AW-1:0]     kwaddr;
  logic [MASK_W-1:0] kwdata, k_rm, k_reg;

  mskmv_decode u_dec (
    .valid (in_valid), .opcode (in_opcode), .pfx (in_pfx), .w (in_w),
    .l (in_l), .mod (in_mod), .mode64 (in_mode64), .dec (dec)
  );

  mskmv_regfile #(.NREG(NREG), .W(MASK_W)) u_kreg (
    .clk (clk), .rst_n (rst_q), .we (kwe), .waddr (kwaddr), .wdata (kwdata),
    .raddr_a (in_rm), .raddr_b (in_reg), .rdata_a (k_rm), .rdata_b (k_reg)
  );

  mskmv_exec #(.NREG(NREG)) u_exe (
    .clk (clk), .rst_n (rst_q), .in_valid (in_valid), .dec (dec),
    .mode64 (in_mode64), .reg_idx (in_reg), .ld_data (ld_data),
    .gpr_rdata (gpr_rdata), .k_rm (k_rm), .k_reg (k_reg),
    .kwe (kwe), .kwaddr (kwaddr), .kwdata (kwdata),
    .gpr_we (gpr_we), .gpr_waddr (gpr_waddr), .gpr_wdata (gpr_wdata),
    .mem_req (mem_req), .mem_we (mem_we), .mem_be (mem_be),
    .mem_wdata (mem_wdata), .ud_fault (ud_fault)
  );

  assert_l_fault_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_l) |=> ud_fault);
  assert_wide32_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_opcode[7:1] == 7'b1001001 && in_pfx == 2'd2 && in_w && !in_mode64)
      |=> (ud_fault && !gpr_we));
  assert_store_mod_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_opcode == 8'h91 && in_mod == 2'b11) |=> (ud_fault && !mem_req));
endmodule

// File: tb/sim_mskmv_unit.sv
module sim_mskmv_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_w, in_l, in_mode64;
  logic [7:0]  in_opcode;
  logic [1:0]  in_pfx, in_mod;
  logic [2:0]  in_reg, in_rm;
  logic [63:0] ld_data, gpr_rdata;
  logic        gpr_we, mem_req, mem_we, ud_fault;
  logic [2:0]  gpr_waddr;
  logic [63:0] gpr_wdata, mem_wdata;
  logic [7:0]  mem_be;

  int tests = 0, fails = 0;
  logic done = 1'b0;

  logic        o_gwe, o_req, o_mwe, o_ud;
  logic [2:0]  o_gaddr;
  logic [63:0] o_gdata, o_wdata;
  logic [7:0]  o_be;

  localparam logic [63:0] P = 64'h1234_5678_9ABC_DEF0;

  always #4 clk = ~clk;

  mskmv_unit u0 (
    .clk, .rst_n, .in_valid, .in_opcode, .in_pfx, .in_w, .in_l, .in_mod,
    .in_reg, .in_rm, .in_mode64, .ld_data, .gpr_rdata, .gpr_we, .gpr_waddr,
    .gpr_wdata, .mem_req, .mem_we, .mem_be, .mem_wdata, .ud_fault
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [1:0] pfx, input logic w, input logic l,
                       input logic [1:0] md, input logic [2:0] rg, input logic [2:0] rm,
                       input logic m64, input logic [63:0] ld, input logic [63:0] gs);
    in_opcode = op; in_pfx = pfx; in_w = w; in_l = l; in_mod = md;
    in_reg = rg; in_rm = rm; in_mode64 = m64; ld_data = ld; gpr_rdata = gs;
    in_valid = 1'b1;
    @(negedge clk);
    o_gwe = gpr_we; o_gaddr = gpr_waddr; o_gdata = gpr_wdata; o_req = mem_req;
    o_mwe = mem_we; o_be = mem_be; o_wdata = mem_wdata; o_ud = ud_fault;
    in_valid = 1'b0;
  endtask

  task automatic wr_k(input logic [2:0] k, input logic [63:0] v);
    issue(8'h92, 2'd2, 1'b1, 1'b0, 2'b11, k, 3'd0, 1'b1, 64'd0, v);
  endtask

  task automatic rd_k(input logic [2:0] k, output logic [63:0] v);
    issue(8'h93, 2'd2, 1'b1, 1'b0, 2'b11, 3'd0, k, 1'b1, 64'd0, 64'd0);
    v = o_gdata;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk("R1", "ud after reset", 64'(ud_fault), 64'd0);
    chk("R1", "gpr_we after reset", 64'(gpr_we), 64'd0);
    chk("R1", "mem_req after reset", 64'(mem_req), 64'd0);
    for (int k = 0; k < 8; k++) begin
      rd_k(3'(k), v);
      chk("R1", $sformatf("k%0d reset value", k), v, 64'd0);
    end
  endtask

  task automatic t_gpr_to_mask;
    logic [63:0] v;
    logic [63:0] g = 64'hFFFF_FFFF_FFFF_FFA5;
    issue(8'h92, 2'd0, 1'b0, 1'b0, 2'b11, 3'd2, 3'd0, 1'b1, 64'd0, g); rd_k(3'd2, v);
    chk("R5 R8", "g2k none/W0", v, 64'hFFA5);
    issue(8'h92, 2'd1, 1'b0, 1'b0, 2'b11, 3'd2, 3'd0, 1'b1, 64'd0, g); rd_k(3'd2, v);
    chk("R5 R8", "g2k 66/W0", v, 64'hA5);
    issue(8'h92, 2'd2, 1'b0, 1'b0, 2'b11, 3'd2, 3'd0, 1'b1, 64'd0, g); rd_k(3'd2, v);
    chk("R5 R8", "g2k F2/W0", v, 64'hFFFF_FFA5);
    issue(8'h92, 2'd2, 1'b1, 1'b0, 2'b11, 3'd2, 3'd0, 1'b1, 64'd0, g); rd_k(3'd2, v);
    chk("R5 R8", "g2k F2/W1", v, g);
    issue(8'h92, 2'd2, 1'b0, 1'b0, 2'b11, 3'd2, 3'd0, 1'b0, 64'd0, 64'h55AA_0000_1234_5678);
    rd_k(3'd2, v);
    chk("R5", "g2k F2/W0 in 32-bit mode", v, 64'h1234_5678);
  endtask

  task automatic t_mask_to_gpr;
    wr_k(3'd1, P);
    issue(8'h93, 2'd0, 1'b0, 1'b0, 2'b11, 3'd6, 3'd1, 1'b1, 64'd0, 64'd0);
    chk("R6 R8", "k2g none/W0 data", o_gdata, 64'hDEF0);
    chk("R6", "k2g we", 64'(o_gwe), 64'd1);
    chk("R6", "k2g waddr", 64'(o_gaddr), 64'd6);
    chk("R6", "k2g no mem", 64'(o_req), 64'd0);
    issue(8'h93, 2'd1, 1'b0, 1'b0, 2'b11, 3'd3, 3'd1, 1'b1, 64'd0, 64'd0);
    chk("R6 R8", "k2g 66/W0", o_gdata, 64'hF0);
    issue(8'h93, 2'd2, 1'b0, 1'b0, 2'b11, 3'd3, 3'd1, 1'b1, 64'd0, 64'd0);
    chk("R6 R8", "k2g F2/W0 64-bit mode", o_gdata, 64'h9ABC_DEF0);
    issue(8'h93, 2'd2, 1'b0, 1'b0, 2'b11, 3'd3, 3'd1, 1'b0, 64'd0, 64'd0);
    chk("R6", "k2g F2/W0 32-bit mode", o_gdata, 64'h9ABC_DEF0);
    issue(8'h93, 2'd0, 1'b0, 1'b0, 2'b11, 3'd3, 3'd1, 1'b0, 64'd0, 64'd0);
    chk("R6", "k2g none/W0 32-bit mode", o_gdata, 64'hDEF0);
  endtask

  task automatic t_copy;
    logic [63:0] v;
    wr_k(3'd1, P);
    issue(8'h90, 2'd0, 1'b0, 1'b0, 2'b11, 3'd3, 3'd1, 1'b1, 64'hDEAD, 64'd0);
    chk("R2", "copy no mem_req", 64'(o_req), 64'd0);
    rd_k(3'd3, v); chk("R2 R7", "copy none/W0", v, 64'hDEF0);
    issue(8'h90, 2'd1, 1'b0, 1'b0, 2'b11, 3'd3, 3'd1, 1'b1, 64'd0, 64'd0);
    rd_k(3'd3, v); chk("R2 R7", "copy 66/W0", v, 64'hF0);
    issue(8'h90, 2'd0, 1'b1, 1'b0, 2'b11, 3'd3, 3'd1, 1'b0, 64'd0, 64'd0);
    rd_k(3'd3, v); chk("R2 R7", "copy none/W1", v, P);
    issue(8'h90, 2'd1, 1'b1, 1'b0, 2'b11, 3'd3, 3'd1, 1'b1, 64'd0, 64'd0);
    rd_k(3'd3, v); chk("R2 R7", "copy 66/W1", v, 64'h9ABC_DEF0);
    rd_k(3'd1, v); chk("R13", "copy source untouched", v, P);
  endtask

  task automatic t_load;
    logic [63:0] v;
    logic [63:0] d = 64'hFEDC_BA98_7654_3210;
    issue(8'h90, 2'd0, 1'b0, 1'b0, 2'b00, 3'd4, 3'd0, 1'b1, d, 64'd0);
    chk("R3", "load req", 64'(o_req), 64'd1);
    chk("R3", "load not store", 64'(o_mwe), 64'd0);
    chk("R3", "load be 16", 64'(o_be), 64'h03);
    rd_k(3'd4, v); chk("R3 R7", "load none/W0", v, 64'h3210);
    issue(8'h90, 2'd1, 1'b1, 1'b0, 2'b10, 3'd4, 3'd0, 1'b1, d, 64'd0);
    chk("R3", "load be 32", 64'(o_be), 64'h0F);
    rd_k(3'd4, v); chk("R3 R7", "load 66/W1", v, 64'h7654_3210);
    issue(8'h90, 2'd0, 1'b1, 1'b0, 2'b01, 3'd4, 3'd0, 1'b1, d, 64'd0);
    chk("R3", "load be 64", 64'(o_be), 64'hFF);
    rd_k(3'd4, v); chk("R3 R7", "load none/W1", v, d);
    issue(8'h90, 2'd1, 1'b0, 1'b0, 2'b00, 3'd4, 3'd0, 1'b1, d, 64'd0);
    rd_k(3'd4, v); chk("R3 R7", "load 66/W0", v, 64'h10);
  endtask

  task automatic t_store;
    logic [63:0] v;
    wr_k(3'd1, P);
    issue(8'h91, 2'd0, 1'b0, 1'b0, 2'b01, 3'd1, 3'd0, 1'b1, 64'd0, 64'd0);
    chk("R4", "store req", 64'(o_req), 64'd1);
    chk("R4", "store we", 64'(o_mwe), 64'd1);
    chk("R4", "store no gpr", 64'(o_gwe), 64'd0);
    chk("R4", "store be 16", 64'(o_be), 64'h03);
    chk("R4", "store data 16", o_wdata, 64'hDEF0);
    issue(8'h91, 2'd1, 1'b0, 1'b0, 2'b00, 3'd1, 3'd0, 1'b1, 64'd0, 64'd0);
    chk("R4", "store be 8", 64'(o_be), 64'h01);
    chk("R4", "store data 8", o_wdata, 64'hF0);
    issue(8'h91, 2'd0, 1'b1, 1'b0, 2'b10, 3'd1, 3'd0, 1'b1, 64'd0, 64'd0);
    chk("R4", "store be 64", 64'(o_be), 64'hFF);
    chk("R4", "store data 64", o_wdata, P);
    issue(8'h91, 2'd1, 1'b1, 1'b0, 2'b00, 3'd1, 3'd0, 1'b0, 64'd0, 64'd0);
    chk("R4", "store be 32", 64'(o_be), 64'h0F);
    chk("R4", "store data 32", o_wdata, 64'h9ABC_DEF0);
    rd_k(3'd1, v); chk("R4", "store leaves mask", v, P);
  endtask

  task automatic t_bad(input string req, input logic [7:0] op, input logic [1:0] pfx,
                       input logic w, input logic l, input logic [1:0] md, input logic m64);
    logic [63:0] v;
    wr_k(3'd5, 64'hA5A5_A5A5_A5A5_A5A5);
    issue(op, pfx, w, l, md, 3'd5, 3'd5, m64, 64'h1111, 64'h2222);
    chk(req, $sformatf("op %h fault", op), 64'(o_ud), 64'd1);
    chk("R12", $sformatf("op %h no gpr write", op), 64'(o_gwe), 64'd0);
    chk("R12", $sformatf("op %h no mem req", op), 64'(o_req), 64'd0);
    @(negedge clk);
    chk("R12", "fault lasts one cycle", 64'(ud_fault), 64'd0);
    rd_k(3'd5, v);
    chk("R12", $sformatf("op %h mask kept", op), v, 64'hA5A5_A5A5_A5A5_A5A5);
  endtask

  task automatic t_undef;
    t_bad("R9",  8'h91, 2'd0, 1'b0, 1'b0, 2'b11, 1'b1);
    t_bad("R9",  8'h92, 2'd0, 1'b0, 1'b0, 2'b00, 1'b1);
    t_bad("R9",  8'h93, 2'd1, 1'b0, 1'b0, 2'b10, 1'b1);
    t_bad("R10", 8'h92, 2'd2, 1'b1, 1'b0, 2'b11, 1'b0);
    t_bad("R10", 8'h93, 2'd2, 1'b1, 1'b0, 2'b11, 1'b0);
    t_bad("R11", 8'h90, 2'd0, 1'b0, 1'b1, 2'b11, 1'b1);
    t_bad("R11", 8'h90, 2'd2, 1'b0, 1'b0, 2'b11, 1'b1);
    t_bad("R11", 8'h92, 2'd0, 1'b1, 1'b0, 2'b11, 1'b1);
    t_bad("R11", 8'h93, 2'd1, 1'b1, 1'b0, 2'b11, 1'b1);
    t_bad("R11", 8'h92, 2'd3, 1'b0, 1'b0, 2'b11, 1'b1);
    t_bad("R11", 8'h94, 2'd0, 1'b0, 1'b0, 2'b11, 1'b1);
  endtask

  task automatic t_timing;
    logic [63:0] v;
    wr_k(3'd7, 64'h0F0F_0000_FFFF_0001);
    rd_k(3'd7, v);
    chk("R13", "read right after write", v, 64'h0F0F_0000_FFFF_0001);
    @(negedge clk);
    chk("R13", "gpr_we drops when idle", 64'(gpr_we), 64'd0);
    chk("R13", "mem_req drops when idle", 64'(mem_req), 64'd0);
    rd_k(3'd6, v);
    chk("R13", "other mask untouched", v, 64'd0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_opcode = 8'h00; in_pfx = 2'd0; in_w = 1'b0;
    in_l = 1'b0; in_mod = 2'b00; in_reg = 3'd0; in_rm = 3'd0; in_mode64 = 1'b1;
    ld_data = 64'd0; gpr_rdata = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_gpr_to_mask;
    t_mask_to_gpr;
    t_copy;
    t_load;
    t_store;
    t_undef;
    t_timing;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule